// File: doc/BRIEF.md
# Halfword Negative Multiply-Accumulate with Saturation

This execution unit performs one arithmetic step for a processor pipeline. It takes the signed lower halves of two source operands, multiplies them, subtracts the product from a 32-bit accumulator operand and clamps the outcome to the signed 32-bit range. Only a sum that leaves that range is clamped; any other sum passes through unchanged. The result and all status outputs are registered and appear one clock after the input strobe.

Two control inputs select optional status updates. One enables an overflow flag write: the overflow bit reports whether clamping took place, and the sticky summary-overflow bit takes the OR of its incoming value and the new overflow bit. The other enables a write of a four-bit condition field. That field holds a signed comparison of the final result against zero plus a copy of the summary-overflow value. The surrounding pipeline applies these writes to its architectural state. The four combinations of the two controls give the four variants of the instruction.

Top module: `halfword_nmac_unit`

## Requirements
- R1: Only bits [15:0] of `src_a` and `src_b` are used, each read as a signed two's-complement value; bits [31:16] of either operand have no effect on any output.
- R2: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `result` equals `acc_in` minus the signed product when that difference lies in [-2^31, 2^31-1].
- R3: When the difference is above 2^31-1, `result` is 0x7FFFFFFF. When it is below -2^31, `result` is 0x80000000. A difference exactly equal to either bound is not treated as overflow.
- R4: The product of -32768 and -32768 (2^30) is subtracted without wraparound. For example, an accumulator of 0 gives 0xC0000000.
- R5: `cr_we` is high exactly when a valid operation had `rec_en` = 1. Of `cr_lt`, `cr_gt` and `cr_eq`, exactly one is set, matching result < 0, result > 0 or result == 0 (signed).
- R6: `ovf_we` is high exactly when a valid operation had `ovf_en` = 1. `ov_out` is 1 if clamping occurred and 0 otherwise.
- R7: When `ovf_en` = 1, `so_out` equals `so_in` OR the new overflow bit. `cr_so` equals that updated value when `ovf_en` = 1, and equals `so_in` when `ovf_en` = 0.
- R8: Synchronous active-high `rst` clears `out_valid`, `result`, `cr_we`, `ovf_we` and all flag outputs to 0.
- R9: After an edge where `in_valid` is low, `out_valid`, `cr_we` and `ovf_we` are 0, and `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| acc_in | input | 32 | Accumulator operand |
| src_a | input | 32 | First multiplicand (low half used) |
| src_b | input | 32 | Second multiplicand (low half used) |
| ovf_en | input | 1 | Enable overflow/summary-overflow update |
| rec_en | input | 1 | Enable condition field update |
| so_in | input | 1 | Current summary-overflow value |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Saturated destination value |
| cr_we | output | 1 | Condition field write enable |
| cr_lt | output | 1 | Result negative |
| cr_gt | output | 1 | Result positive |
| cr_eq | output | 1 | Result zero |
| cr_so | output | 1 | Summary-overflow copy in the condition field |
| ovf_we | output | 1 | Overflow status write enable |
| ov_out | output | 1 | Saturation occurred |
| so_out | output | 1 | Updated summary-overflow value |

## Verification
The hardest cases to reach are sums that land exactly on a range bound, or one step beyond it. Random operands almost never hit them, because the 16x16 product is small next to the accumulator range. The stimulus therefore places the accumulator at or next to 0x7FFFFFFF and 0x80000000 and picks products of +1, -1 and the extreme 2^30, so that both clamp directions and both exact limits occur. Random vectors then sweep the control combinations and the garbage in the upper operand halves.

// File: rtl/nmac_pkg.sv
package nmac_pkg;

    localparam int NMAC_DW = 32;
    localparam int NMAC_HW = 16;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cr_field_t;

    typedef struct packed {
        logic ov;
        logic so;
    } ovf_status_t;

    // Signed three-way compare of a value against zero.
    function automatic cr_field_t cmp_zero(input logic [NMAC_DW-1:0] v, input logic so);
        cr_field_t c;
        c.lt = v[NMAC_DW-1];
        c.eq = (v == '0);
        c.gt = !v[NMAC_DW-1] && (v != '0);
        c.so = so;
        return c;
    endfunction

endpackage

// File: rtl/nmac_arith.sv
module nmac_arith
    import nmac_pkg::*;
#(
    parameter int DATA_W = NMAC_DW,
    parameter int HALF_W = NMAC_HW
) (
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] value,
    output logic              clamped
);
    localparam int PROD_W = 2 * HALF_W;
    localparam int EXT_W  = DATA_W + 1;
    localparam int PAD_W  = EXT_W - PROD_W;

    logic signed [HALF_W-1:0] a_lo, b_lo;
    logic signed [PROD_W-1:0] prod;
    logic        [EXT_W-1:0]  prod_x, nprod, acc_x, sum;
    logic                     acc_sign;

    always_comb begin
        a_lo     = opa[HALF_W-1:0];
        b_lo     = opb[HALF_W-1:0];
        prod     = a_lo * b_lo;
        // widened before negation so 2^30 never wraps
        prod_x   = {{PAD_W{prod[PROD_W-1]}}, prod};
        nprod    = ~prod_x + EXT_W'(1);
        acc_sign = acc[DATA_W-1];
        acc_x    = {acc_sign, acc};
        sum      = acc_x + nprod;
        clamped  = (nprod[EXT_W-1] == acc_sign) && (sum[DATA_W-1] != acc_sign);
        if (clamped)
            value = {acc_sign, {(DATA_W-1){~acc_sign}}};
        else
            value = sum[DATA_W-1:0];
    end

endmodule

// File: rtl/nmac_flags.sv
module nmac_flags
    import nmac_pkg::*;
(
    input  logic [NMAC_DW-1:0] value,
    input  logic               clamped,
    input  logic               ovf_en,
    input  logic               so_prev,
    output cr_field_t          cr,
    output ovf_status_t        st
);
    always_comb begin
        st.ov = clamped;
        st.so = ovf_en ? (so_prev | clamped) : so_prev;
        cr    = cmp_zero(value, st.so);
    end

endmodule

// File: rtl/halfword_nmac_unit.sv
module halfword_nmac_unit
    import nmac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] acc_in,
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    input  logic        ovf_en,
    input  logic        rec_en,
    input  logic        so_in,
    output logic        out_valid,
    output logic [31:0] result,
    output logic        cr_we,
    output logic        cr_lt,
    output logic        cr_gt,
    output logic        cr_eq,
    output logic        cr_so,
    output logic        ovf_we,
    output logic        ov_out,
    output logic        so_out
);
    logic [NMAC_DW-1:0] nx_value;
    logic               nx_clamped;
    cr_field_t          nx_cr, cr_q;
    ovf_status_t        nx_st, st_q;

    nmac_arith #(.DATA_W(NMAC_DW), .HALF_W(NMAC_HW)) u_arith (
        .acc     (acc_in),
        .opa     (src_a),
        .opb     (src_b),
        .value   (nx_value),
        .clamped (nx_clamped)
    );

    nmac_flags u_flags (
        .value   (nx_value),
        .clamped (nx_clamped),
        .ovf_en  (ovf_en),
        .so_prev (so_in),
        .cr      (nx_cr),
        .st      (nx_st)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            cr_we     <= 1'b0;
            ovf_we    <= 1'b0;
            cr_q      <= '0;
            st_q      <= '0;
        end else begin
            out_valid <= in_valid;
            cr_we     <= in_valid && rec_en;
            ovf_we    <= in_valid && ovf_en;
            if (in_valid) begin
                result <= nx_value;
                cr_q   <= nx_cr;
                st_q   <= nx_st;
            end
        end
    end

    assign cr_lt  = cr_q.lt;
    assign cr_gt  = cr_q.gt;
    assign cr_eq  = cr_q.eq;
    assign cr_so  = cr_q.so;
    assign ov_out = st_q.ov;
    assign so_out = st_q.so;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_SAT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (ovf_we && ov_out) |-> (result == 32'h7FFF_FFFF || result == 32'h8000_0000)); // R3
    AST_CR_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
        cr_we |-> ($countones({cr_lt, cr_gt, cr_eq}) == 1)); // R5
    AST_CR_SIGN: assert property (@(posedge clk) disable iff (rst)
        cr_we |-> (cr_lt == result[31])); // R5
    AST_OVF_WE_GATE: assert property (@(posedge clk) disable iff (rst)
        ovf_we |-> $past(in_valid && ovf_en)); // R6
    AST_SO_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_we |-> (so_out == ($past(so_in) | ov_out))); // R7
    AST_CR_SO_COPY: assert property (@(posedge clk) disable iff (rst)
        (cr_we && ovf_we) |-> (cr_so == so_out)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!cr_we && !ovf_we && $stable(result))); // R9

endmodule

// File: tb/halfword_nmac_unit_tb.sv
module halfword_nmac_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] acc_in, src_a, src_b;
    logic        ovf_en, rec_en, so_in;
    logic        out_valid, cr_we, cr_lt, cr_gt, cr_eq, cr_so, ovf_we, ov_out, so_out;
    logic [31:0] result;

    int total = 0;
    int bad   = 0;
    logic [31:0] exp_res = '0;

    always #2 clk = ~clk;

    halfword_nmac_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .acc_in(acc_in),
        .src_a(src_a), .src_b(src_b), .ovf_en(ovf_en), .rec_en(rec_en),
        .so_in(so_in), .out_valid(out_valid), .result(result),
        .cr_we(cr_we), .cr_lt(cr_lt), .cr_gt(cr_gt), .cr_eq(cr_eq),
        .cr_so(cr_so), .ovf_we(ovf_we), .ov_out(ov_out), .so_out(so_out)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock: drive at falling edge, model, check after the rising edge.
    task automatic step(input string tag, input logic v, input logic [31:0] acc,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic oe, input logic rc, input logic so);
        longint pa, pb, t;
        logic   ovf, so_new;
        @(negedge clk);
        in_valid = v; acc_in = acc; src_a = a; src_b = b;
        ovf_en = oe; rec_en = rc; so_in = so;
        pa = longint'($signed(a[15:0]));
        pb = longint'($signed(b[15:0]));
        t  = longint'($signed(acc)) - pa * pb;
        ovf = 1'b0;
        if (t > 64'sd2147483647) begin t = 64'sd2147483647; ovf = 1'b1; end
        if (t < -64'sd2147483648) begin t = -64'sd2147483648; ovf = 1'b1; end
        so_new = oe ? (so | ovf) : so;
        @(posedge clk);
        #1;
        if (v) exp_res = t[31:0];
        chk(tag, "out_valid", {31'd0, out_valid}, {31'd0, v});
        chk(tag, "result", result, exp_res);
        chk(tag, "cr_we", {31'd0, cr_we}, {31'd0, v & rc});
        chk(tag, "ovf_we", {31'd0, ovf_we}, {31'd0, v & oe});
        if (v && rc)
            chk(tag, "cr_lt_gt_eq_so", {28'd0, cr_lt, cr_gt, cr_eq, cr_so},
                {28'd0, t < 0, t > 0, t == 0, so_new});
        if (v && oe)
            chk(tag, "ov_so", {30'd0, ov_out, so_out}, {30'd0, ovf, so_new});
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 0; acc_in = 0; src_a = 0; src_b = 0;
        ovf_en = 0; rec_en = 0; so_in = 0;
        repeat (3) @(posedge clk);
        #1;
        // R8: reset state
        chk("R8", "reset outs",
            {23'd0, out_valid, cr_we, ovf_we, cr_lt, cr_gt, cr_eq, cr_so, ov_out, so_out},
            32'd0);
        chk("R8", "reset result", result, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // R2: plain in-range operations
        step("R2", 1, 32'd1000, 32'd3, 32'd7, 1, 1, 0);
        step("R2", 1, 32'hFFFF_FF00, 32'h0000_FFFE, 32'd5, 1, 1, 0);
        step("R2", 1, 32'd21, 32'd3, 32'd7, 1, 1, 0);          // zero result
        // R1: garbage in upper halves
        step("R1", 1, 32'd50, 32'hDEAD_0004, 32'hBEEF_0003, 1, 1, 0);
        step("R1", 1, 32'd50, 32'h1234_FFFF, 32'hFFFF_0002, 0, 1, 0);
        // R3: positive clamp and exact upper bound
        step("R3", 1, 32'h7FFF_FFFF, 32'd1, 32'hFFFF_FFFF, 1, 1, 0);
        step("R3", 1, 32'h7FFF_FFFE, 32'd1, 32'hFFFF_FFFF, 1, 1, 0);
        // R3: negative clamp and exact lower bound
        step("R3", 1, 32'h8000_0000, 32'd1, 32'd1, 1, 1, 0);
        step("R3", 1, 32'h8000_0001, 32'd1, 32'd1, 1, 1, 0);
        // R4: extreme product
        step("R4", 1, 32'd0, 32'h0000_8000, 32'h0000_8000, 1, 1, 0);
        step("R4", 1, 32'hC000_0000, 32'h0000_8000, 32'h0000_8000, 1, 1, 0);
        step("R4", 1, 32'hBFFF_FFFF, 32'h0000_8000, 32'h0000_8000, 1, 1, 0);
        // R5/R6/R7: control combinations and sticky summary bit
        step("R5", 1, 32'h8000_0000, 32'd1, 32'd1, 0, 1, 1);
        step("R6", 1, 32'h8000_0000, 32'd1, 32'd1, 1, 0, 0);
        step("R7", 1, 32'd10, 32'd1, 32'd1, 1, 1, 1);
        step("R7", 1, 32'd10, 32'd1, 32'd1, 0, 0, 0);
        // R9: idle cycles hold result, no writes
        step("R9", 0, 32'h7FFF_FFFF, 32'd9, 32'd9, 1, 1, 1);
        step("R9", 0, 32'd0, 32'd0, 32'd0, 1, 1, 0);
        // random sweep
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            step("R2", r[0] | r[1], (r[4:2] == 0) ? {r[5], {31{~r[5]}}} : $urandom,
                 $urandom, $urandom, r[6], r[7], r[8]);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule